// File: doc/BRIEF.md
# Serial Command Decoder with Register Port

This block is a serial slave port. It sits behind a chip-select framed, clocked serial link. The leading bits of each frame choose one of three command classes.

- A conversion-start command carries an input-select field, a gain code and a polarity flag. The block turns it into a one-cycle start strobe and holds the fields for the converter.
- A DAC command either loads or reads back one of two 12-bit output codes.
- A register-mode command carries a read/write flag and a 5-bit address. The length of its data field depends on the register being addressed.

The converters themselves are modelled only as registers. The DAC codes are registers inside the block, and the conversion result arrives on an input port.

All serial inputs are resynchronised to the system clock. A frame takes effect only when its final bit has been received with chip select still low. Raising chip select at any earlier point throws the partial frame away. Read data is shifted out on the falling serial-clock edge, so the master samples it on the rising edge.

Top module: `sercmd_port`

## Requirements
- R1: After reset, `miso`, both DAC codes, all strobes and the held conversion fields are 0.
- R2: The frame `1, mux[3:0], gain[1:0], bip` (8 bits, MSB first) gives exactly one `conv_start` pulse. From that pulse on, `conv_mux`, `conv_gain` and `conv_bip` hold the received fields, and they change at no other time.
- R3: The frame `0, 1, 0, ch, code[11:0]` loads `code` into channel A (`ch`=0) or channel B (`ch`=1). It pulses only that channel's load strobe, and a DAC code changes only in the cycle its strobe is high.
- R4: The frame `0, 1, 1, ch` followed by 12 clocks returns that channel's code MSB first on `miso`. It changes no register and raises no strobe.
- R5: The register-mode header is `0, 0, rw, adr[4:0]` with rw=0 for write and 1 for read. Data lengths by address: 0x01 = 8 bits, 0x02 = 16 bits, 0x03 = 16 bits, 0x04 = 24 bits, 0x05 = 256 bits.
- R6: A register write commits the whole data field. A later read of the same address returns it MSB first, starting at the bit after the header.
- R7: Address 0x03 reads as `{4'b0, adc_result}`. Writes to it are discarded.
- R8: Any other address takes 8 data bits. A write to it changes no register, and a read of it returns zeros.
- R9: A frame cut short before its final bit commits nothing and raises no strobe.
- R10: While chip select is high, no strobe is raised. The next frame is decoded from its first bit.
- R11: `miso` changes only after a detected falling serial-clock edge, or to 0 while chip select is high.
- R12: Bits clocked after a frame's final bit, before chip select rises, are ignored.
- R13: If chip select rises on the same synchronised cycle as the final rising edge, the frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| adc_result | input | 12 | Latest conversion result |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_mux | output | 4 | Held input-select field |
| conv_gain | output | 2 | Held gain code |
| conv_bip | output | 1 | Held polarity flag |
| dac_a | output | 12 | Channel A code |
| dac_b | output | 12 | Channel B code |
| dac_load_a | output | 1 | Channel A load strobe |
| dac_load_b | output | 1 | Channel B load strobe |

## Verification
The commit of a frame's last bit and the abort from chip select can land in the same synchronised cycle. The bench provokes this by raising `sclk` and `cs_n` together on the final bit of a register write and of a DAC write. Chip select must win: the register read back afterwards holds its old value, and the load strobe count does not move. Truncated frames and over-long frames bracket the same boundary from either side.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam int ADR_W    = 5;
  localparam int LEN_W    = 9;
  localparam int MAX_DATA = 256;
  localparam int CTRL_W   = 8;
  localparam int SETUP_W  = 16;
  localparam int RES_W    = 16;
  localparam int ACCUM_W  = 24;
  localparam int WAVE_W   = MAX_DATA;
  localparam int HDR_BITS = 8;

  localparam logic [ADR_W-1:0] A_CTRL   = 5'h01;
  localparam logic [ADR_W-1:0] A_SETUP  = 5'h02;
  localparam logic [ADR_W-1:0] A_RESULT = 5'h03;
  localparam logic [ADR_W-1:0] A_ACCUM  = 5'h04;
  localparam logic [ADR_W-1:0] A_WAVE   = 5'h05;

  typedef enum logic [2:0] {
    CLS_IDLE, CLS_ZERO, CLS_CONV, CLS_DAC, CLS_REG
  } cls_e;

  function automatic logic [LEN_W-1:0] data_len(input logic [ADR_W-1:0] a);
    case (a)
      A_CTRL:   data_len = LEN_W'(CTRL_W);
      A_SETUP:  data_len = LEN_W'(SETUP_W);
      A_RESULT: data_len = LEN_W'(RES_W);
      A_ACCUM:  data_len = LEN_W'(ACCUM_W);
      A_WAVE:   data_len = LEN_W'(WAVE_W);
      default:  data_len = LEN_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sercmd_decoder.sv
module sercmd_decoder
  import sercmd_pkg::*;
#(
  parameter int DAC_W  = 12,
  parameter int MUX_W  = 4,
  parameter int GAIN_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n_s,
  input  logic                 sclk_s,
  input  logic                 din_s,
  output logic                 sclk_fall,
  output logic                 go_conv,
  output logic [MUX_W-1:0]     cmux_nx,
  output logic [GAIN_W-1:0]    cgain_nx,
  output logic                 cbip_nx,
  output logic                 wr_dac,
  output logic                 wr_ch,
  output logic                 wr_reg,
  output logic [ADR_W-1:0]     wr_adr,
  output logic [MAX_DATA-1:0]  wr_data,
  output logic                 rd_load,
  output logic                 rd_dac,
  output logic                 rd_ch,
  output logic [ADR_W-1:0]     rd_adr
);
  localparam int CONV_LEN = 2 + MUX_W + GAIN_W;
  localparam int DAC_LEN  = 4 + DAC_W;
  localparam int HDR_W    = (CONV_LEN > HDR_BITS) ? CONV_LEN : HDR_BITS;
  localparam logic [LEN_W-1:0] C_RW   = LEN_W'(2);
  localparam logic [LEN_W-1:0] C_CH   = LEN_W'(3);
  localparam logic [LEN_W-1:0] C_HDR  = LEN_W'(HDR_BITS - 1);
  localparam logic [LEN_W-1:0] C_CONV = LEN_W'(CONV_LEN - 1);
  localparam logic [LEN_W-1:0] C_DAC  = LEN_W'(DAC_LEN - 1);

  logic                sclk_d;
  logic [LEN_W-1:0]    cnt_q, cnt_nx;
  cls_e                cls_q, cls_nx;
  logic                rw_q, rw_nx, ch_q, ch_nx, done_q, done_nx;
  logic [ADR_W-1:0]    adr_q, adr_nx;
  logic [LEN_W-1:0]    len_q, len_nx;
  logic [HDR_W-1:0]    hdr_q, hdr_nx, hdr_sh;
  logic [MAX_DATA-1:0] rx_q, rx_nx, rx_sh;
  logic                sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;
  assign hdr_sh    = {hdr_q[HDR_W-2:0], din_s};
  assign rx_sh     = {rx_q[MAX_DATA-2:0], din_s};

  assign cmux_nx  = hdr_sh[CONV_LEN-2 -: MUX_W];
  assign cgain_nx = hdr_sh[GAIN_W:1];
  assign cbip_nx  = hdr_sh[0];
  assign wr_ch    = ch_q;
  assign wr_adr   = adr_q;
  assign wr_data  = rx_sh;
  assign rd_dac   = (cls_q == CLS_DAC);
  assign rd_ch    = din_s;
  assign rd_adr   = hdr_sh[ADR_W-1:0];

  always_comb begin
    cnt_nx = cnt_q;  cls_nx = cls_q;  rw_nx = rw_q;  ch_nx = ch_q;
    adr_nx = adr_q;  len_nx = len_q;  done_nx = done_q;
    hdr_nx = hdr_q;  rx_nx = rx_q;
    go_conv = 1'b0;  wr_dac = 1'b0;  wr_reg = 1'b0;  rd_load = 1'b0;
    if (cs_n_s) begin
      cnt_nx  = '0;
      cls_nx  = CLS_IDLE;
      done_nx = 1'b0;
    end else if (sclk_rise && !done_q) begin
      cnt_nx = cnt_q + 1'b1;
      hdr_nx = hdr_sh;
      rx_nx  = rx_sh;
      case (cls_q)
        CLS_IDLE: cls_nx = din_s ? CLS_CONV : CLS_ZERO;
        CLS_ZERO: cls_nx = din_s ? CLS_DAC : CLS_REG;
        CLS_CONV: begin
          if (cnt_q == C_CONV) begin
            go_conv = 1'b1;
            done_nx = 1'b1;
          end
        end
        CLS_DAC: begin
          if (cnt_q == C_RW) rw_nx = din_s;
          if (cnt_q == C_CH) begin
            ch_nx   = din_s;
            rd_load = rw_q;
          end
          if (cnt_q == C_DAC) begin
            wr_dac  = ~rw_q;
            done_nx = 1'b1;
          end
        end
        CLS_REG: begin
          if (cnt_q == C_RW) rw_nx = din_s;
          if (cnt_q == C_HDR) begin
            adr_nx  = hdr_sh[ADR_W-1:0];
            len_nx  = data_len(hdr_sh[ADR_W-1:0]);
            rd_load = rw_q;
          end
          if (cnt_q > C_HDR && cnt_q == len_q + C_HDR) begin
            wr_reg  = ~rw_q;
            done_nx = 1'b1;
          end
        end
        default: cls_nx = CLS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;  cnt_q <= '0;  cls_q <= CLS_IDLE;
      rw_q <= 1'b0;    ch_q <= 1'b0; done_q <= 1'b0;
      adr_q <= '0;     len_q <= '0;  hdr_q <= '0;  rx_q <= '0;
    end else begin
      sclk_d <= sclk_s;  cnt_q <= cnt_nx;  cls_q <= cls_nx;
      rw_q <= rw_nx;     ch_q <= ch_nx;    done_q <= done_nx;
      adr_q <= adr_nx;   len_q <= len_nx;  hdr_q <= hdr_nx;  rx_q <= rx_nx;
    end
  end
endmodule

// File: rtl/sercmd_regs.sv
module sercmd_regs
  import sercmd_pkg::*;
#(
  parameter int DAC_W  = 12,
  parameter int MUX_W  = 4,
  parameter int GAIN_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_conv,
  input  logic [MUX_W-1:0]    cmux_nx,
  input  logic [GAIN_W-1:0]   cgain_nx,
  input  logic                cbip_nx,
  input  logic                wr_dac,
  input  logic                wr_ch,
  input  logic                wr_reg,
  input  logic [ADR_W-1:0]    wr_adr,
  input  logic [MAX_DATA-1:0] wr_data,
  input  logic                rd_dac,
  input  logic                rd_ch,
  input  logic [ADR_W-1:0]    rd_adr,
  input  logic [DAC_W-1:0]    adc_result,
  output logic [MAX_DATA-1:0] rd_word,
  output logic                conv_start,
  output logic [MUX_W-1:0]    conv_mux,
  output logic [GAIN_W-1:0]   conv_gain,
  output logic                conv_bip,
  output logic [DAC_W-1:0]    dac_a,
  output logic [DAC_W-1:0]    dac_b,
  output logic                dac_load_a,
  output logic                dac_load_b
);
  localparam int NCH = 2;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [SETUP_W-1:0] setup_q;
  logic [ACCUM_W-1:0] accum_q;
  logic [WAVE_W-1:0]  wave_q;
  logic [DAC_W-1:0]   dac_q  [NCH];
  logic [NCH-1:0]     load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;  setup_q <= '0;  accum_q <= '0;  wave_q <= '0;
    end else if (wr_reg) begin
      if (wr_adr == A_CTRL)  ctrl_q  <= wr_data[CTRL_W-1:0];
      if (wr_adr == A_SETUP) setup_q <= wr_data[SETUP_W-1:0];
      if (wr_adr == A_ACCUM) accum_q <= wr_data[ACCUM_W-1:0];
      if (wr_adr == A_WAVE)  wave_q  <= wr_data[WAVE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start <= 1'b0;  conv_mux <= '0;  conv_gain <= '0;  conv_bip <= 1'b0;
    end else begin
      conv_start <= go_conv;
      if (go_conv) begin
        conv_mux  <= cmux_nx;
        conv_gain <= cgain_nx;
        conv_bip  <= cbip_nx;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_dac
    logic hit;
    assign hit = wr_dac && (wr_ch == c[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dac_q[c]  <= '0;
        load_q[c] <= 1'b0;
      end else begin
        load_q[c] <= hit;
        if (hit) dac_q[c] <= wr_data[DAC_W-1:0];
      end
    end
  end

  assign dac_a      = dac_q[0];
  assign dac_b      = dac_q[1];
  assign dac_load_a = load_q[0];
  assign dac_load_b = load_q[1];

  always_comb begin
    rd_word = '0;
    if (rd_dac) begin
      rd_word[MAX_DATA-1 -: DAC_W] = dac_q[rd_ch];
    end else begin
      case (rd_adr)
        A_CTRL:   rd_word[MAX_DATA-1 -: CTRL_W]  = ctrl_q;
        A_SETUP:  rd_word[MAX_DATA-1 -: SETUP_W] = setup_q;
        A_RESULT: rd_word[MAX_DATA-1 -: RES_W]   = RES_W'(adc_result);
        A_ACCUM:  rd_word[MAX_DATA-1 -: ACCUM_W] = accum_q;
        A_WAVE:   rd_word = wave_q;
        default:  rd_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/sercmd_tx.sv
module sercmd_tx #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n_s,
  input  logic         fall,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         miso
);
  logic [W-1:0] tx_q, tx_nx;
  logic         miso_nx;

  always_comb begin
    tx_nx   = tx_q;
    miso_nx = miso;
    if (cs_n_s) begin
      tx_nx   = '0;
      miso_nx = 1'b0;
    end else if (load) begin
      tx_nx = word;
    end else if (fall) begin
      miso_nx = tx_q[W-1];
      tx_nx   = {tx_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      miso <= 1'b0;
    end else begin
      tx_q <= tx_nx;
      miso <= miso_nx;
    end
  end
endmodule

// File: rtl/sercmd_port.sv
module sercmd_port
  import sercmd_pkg::*;
#(
  parameter int DAC_W       = 12,
  parameter int MUX_W       = 4,
  parameter int GAIN_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  input  logic [DAC_W-1:0]  adc_result,
  output logic              conv_start,
  output logic [MUX_W-1:0]  conv_mux,
  output logic [GAIN_W-1:0] conv_gain,
  output logic              conv_bip,
  output logic [DAC_W-1:0]  dac_a,
  output logic [DAC_W-1:0]  dac_b,
  output logic              dac_load_a,
  output logic              dac_load_b
);
  logic [2:0]          pins_s;
  logic                cs_n_s, sclk_s, din_s, sclk_fall;
  logic                go_conv, wr_dac, wr_ch, wr_reg, rd_load, rd_dac, rd_ch, cbip_nx;
  logic [MUX_W-1:0]    cmux_nx;
  logic [GAIN_W-1:0]   cgain_nx;
  logic [ADR_W-1:0]    wr_adr, rd_adr;
  logic [MAX_DATA-1:0] wr_data, rd_word;

  sercmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, mosi}), .q(pins_s));

  assign {cs_n_s, sclk_s, din_s} = pins_s;

  sercmd_decoder #(.DAC_W(DAC_W), .MUX_W(MUX_W), .GAIN_W(GAIN_W)) i_dec (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .din_s(din_s),
    .sclk_fall(sclk_fall), .go_conv(go_conv), .cmux_nx(cmux_nx),
    .cgain_nx(cgain_nx), .cbip_nx(cbip_nx), .wr_dac(wr_dac), .wr_ch(wr_ch),
    .wr_reg(wr_reg), .wr_adr(wr_adr), .wr_data(wr_data), .rd_load(rd_load),
    .rd_dac(rd_dac), .rd_ch(rd_ch), .rd_adr(rd_adr));

  sercmd_regs #(.DAC_W(DAC_W), .MUX_W(MUX_W), .GAIN_W(GAIN_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .go_conv(go_conv), .cmux_nx(cmux_nx),
    .cgain_nx(cgain_nx), .cbip_nx(cbip_nx), .wr_dac(wr_dac), .wr_ch(wr_ch),
    .wr_reg(wr_reg), .wr_adr(wr_adr), .wr_data(wr_data), .rd_dac(rd_dac),
    .rd_ch(rd_ch), .rd_adr(rd_adr), .adc_result(adc_result), .rd_word(rd_word),
    .conv_start(conv_start), .conv_mux(conv_mux), .conv_gain(conv_gain),
    .conv_bip(conv_bip), .dac_a(dac_a), .dac_b(dac_b),
    .dac_load_a(dac_load_a), .dac_load_b(dac_load_b));

  sercmd_tx #(.W(MAX_DATA)) i_tx (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .fall(sclk_fall),
    .load(rd_load), .word(rd_word), .miso(miso));
endmodule

// File: rtl/sercmd_chk.sv
module sercmd_chk #(
  parameter int DAC_W  = 12,
  parameter int MUX_W  = 4,
  parameter int GAIN_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_s,
  input logic              sclk_fall,
  input logic              miso,
  input logic              conv_start,
  input logic [MUX_W-1:0]  conv_mux,
  input logic [GAIN_W-1:0] conv_gain,
  input logic              conv_bip,
  input logic [DAC_W-1:0]  dac_a,
  input logic [DAC_W-1:0]  dac_b,
  input logic              dac_load_a,
  input logic              dac_load_b
);
  AST_CONV_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |-> $stable({conv_mux, conv_gain, conv_bip})); // R2

  AST_DAC_A_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_a) |-> dac_load_a); // R3

  AST_DAC_B_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_b) |-> dac_load_b); // R3

  AST_NO_STROBE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !(conv_start || dac_load_a || dac_load_b)); // R10

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sclk_fall) || $past(cs_n_s))); // R11
endmodule

bind sercmd_port sercmd_chk #(.DAC_W(DAC_W), .MUX_W(MUX_W), .GAIN_W(GAIN_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_fall(sclk_fall), .miso(miso),
  .conv_start(conv_start), .conv_mux(conv_mux), .conv_gain(conv_gain),
  .conv_bip(conv_bip), .dac_a(dac_a), .dac_b(dac_b),
  .dac_load_a(dac_load_a), .dac_load_b(dac_load_b));

// File: tb/test_sercmd_port.sv
`timescale 1ns/1ps
module test_sercmd_port;
  localparam int H = 8;

  typedef struct packed {
    logic [1:0]  kind;   // 0 conv, 1 write A, 2 write B, 3 DAC read
    logic [4:0]  n;
    logic [15:0] bits;
    logic [11:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 5'd8,  16'h00D3, 12'h053},
    '{2'd1, 5'd16, 16'h45A3, 12'h5A3},
    '{2'd2, 5'd16, 16'h5C3F, 12'hC3F},
    '{2'd3, 5'd16, 16'h6000, 12'h5A3},
    '{2'd3, 5'd16, 16'h7000, 12'hC3F},
    '{2'd0, 5'd8,  16'h009E, 12'h01E},
    '{2'd1, 5'd16, 16'h4FFF, 12'hFFF},
    '{2'd2, 5'd16, 16'h5000, 12'h000}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [11:0] adc_result = '0;
  logic miso, conv_start, conv_bip, dac_load_a, dac_load_b;
  logic [3:0] conv_mux;
  logic [1:0] conv_gain;
  logic [11:0] dac_a, dac_b;
  int nchk = 0, nfail = 0, nconv = 0, nla = 0, nlb = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sercmd_port i_sercmd_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .adc_result(adc_result), .conv_start(conv_start), .conv_mux(conv_mux),
    .conv_gain(conv_gain), .conv_bip(conv_bip), .dac_a(dac_a), .dac_b(dac_b),
    .dac_load_a(dac_load_a), .dac_load_b(dac_load_b));

  always @(posedge clk) begin
    if (conv_start) nconv++;
    if (dac_load_a) nla++;
    if (dac_load_b) nlb++;
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bit n-1 of t goes first; r[k] is miso sampled before the rise of bit k
  task automatic xfer(input logic [271:0] t, input int n, input bit cut,
                      output logic [271:0] r);
    r = '0;
    cs_n = 1'b0;
    wait_n(H);
    for (int k = n - 1; k >= 0; k--) begin
      mosi = t[k];
      wait_n(H);
      r[k] = miso;
      sclk = 1'b1;
      if (cut && k == 0) cs_n = 1'b1;
      wait_n(H);
      sclk = 1'b0;
    end
    wait_n(H);
    cs_n = 1'b1;
    wait_n(2 * H);
  endtask

  initial begin : main
    logic [271:0] r;
    logic [255:0] wv;
    int c0, a0, b0;
    wv = {32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210,
          32'hA5A5A5A5, 32'h5A5A5A5A, 32'h0F0F0F0F, 32'hF0F0F0F0};
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    // R1 reset state
    chk("R1 dac_a", 256'(dac_a), 0);
    chk("R1 dac_b", 256'(dac_b), 0);
    chk("R1 conv fields", 256'({conv_mux, conv_gain, conv_bip}), 0);
    chk("R1 miso/strobes", 256'({miso, conv_start, dac_load_a, dac_load_b}), 0);

    for (int i = 0; i < 8; i++) begin
      c0 = nconv; a0 = nla; b0 = nlb;
      xfer(272'(VEC[i].bits), int'(VEC[i].n), 1'b0, r);
      case (VEC[i].kind)
        2'd0: begin
          chk("R2 conv pulse count", 256'(nconv - c0), 1);
          chk("R2 conv fields", 256'({conv_mux, conv_gain, conv_bip}), 256'(VEC[i].exp[6:0]));
        end
        2'd1: begin
          chk("R3 dac_a code", 256'(dac_a), 256'(VEC[i].exp));
          chk("R3 load strobes A/B", 256'({nla - a0, nlb - b0}), 256'({32'd1, 32'd0}));
        end
        2'd2: begin
          chk("R3 dac_b code", 256'(dac_b), 256'(VEC[i].exp));
          chk("R3 load strobes A/B", 256'({nla - a0, nlb - b0}), 256'({32'd0, 32'd1}));
        end
        default: begin
          chk("R4 readback", 256'(r[11:0]), 256'(VEC[i].exp));
          chk("R4 no strobe", 256'({nla - a0, nlb - b0, nconv - c0}), 0);
        end
      endcase
      chk("R11 miso idle", 256'(miso), 0);
    end

    // R5 R6 register mode, each length
    xfer(272'({3'b000, 5'h01, 8'hA5}), 16, 1'b0, r);
    xfer(272'({3'b001, 5'h01, 8'h00}), 16, 1'b0, r);
    chk("R6 ctrl 8b", 256'(r[7:0]), 256'h A5);
    xfer(272'({3'b000, 5'h02, 16'hBEEF}), 24, 1'b0, r);
    xfer(272'({3'b001, 5'h02, 16'h0}), 24, 1'b0, r);
    chk("R5 setup 16b", 256'(r[15:0]), 256'hBEEF);
    xfer(272'({3'b000, 5'h04, 24'h123456}), 32, 1'b0, r);
    xfer(272'({3'b001, 5'h04, 24'h0}), 32, 1'b0, r);
    chk("R5 accum 24b", 256'(r[23:0]), 256'h123456);
    xfer(272'({3'b000, 5'h05, wv}), 264, 1'b0, r);
    xfer(272'({3'b001, 5'h05, 256'h0}), 264, 1'b0, r);
    chk("R6 wave 256b", r[255:0], wv);

    // R7 result register
    adc_result = 12'h9C4;
    xfer(272'({3'b000, 5'h03, 16'hFFFF}), 24, 1'b0, r);
    xfer(272'({3'b001, 5'h03, 16'h0}), 24, 1'b0, r);
    chk("R7 result read", 256'(r[15:0]), 256'h09C4);

    // R8 unknown address
    xfer(272'({3'b000, 5'h1F, 8'h3C}), 16, 1'b0, r);
    xfer(272'({3'b001, 5'h01, 8'h00}), 16, 1'b0, r);
    chk("R8 ctrl untouched", 256'(r[7:0]), 256'hA5);
    xfer(272'({3'b001, 5'h1F, 8'hFF}), 16, 1'b0, r);
    chk("R8 unknown reads zero", 256'(r[7:0]), 0);

    // R9 truncated frames
    c0 = nconv; a0 = nla;
    xfer(272'(16'h4111 >> 4), 12, 1'b0, r);
    xfer(272'(8'hD3 >> 2), 6, 1'b0, r);
    xfer(272'({3'b000, 5'h01, 8'h11} >> 1), 15, 1'b0, r);
    chk("R9 dac_a kept", 256'(dac_a), 256'hFFF);
    chk("R9 no strobes", 256'({nla - a0, nconv - c0}), 0);
    xfer(272'({3'b001, 5'h01, 8'h00}), 16, 1'b0, r);
    chk("R9 ctrl kept", 256'(r[7:0]), 256'hA5);

    // R10 decoding restarts after an abort
    c0 = nconv;
    xfer(272'(8'hD3 >> 3), 5, 1'b0, r);
    xfer(272'(8'h9E), 8, 1'b0, r);
    chk("R10 fresh conv", 256'({nconv - c0, 25'd0, conv_mux, conv_gain, conv_bip}),
        256'({32'd1, 25'd0, 7'h1E}));

    // R13 deselect on final rising edge
    a0 = nla;
    xfer(272'({3'b000, 5'h01, 8'h77}), 16, 1'b1, r);
    xfer(272'(16'h4123), 16, 1'b1, r);
    xfer(272'({3'b001, 5'h01, 8'h00}), 16, 1'b0, r);
    chk("R13 ctrl kept", 256'(r[7:0]), 256'hA5);
    chk("R13 no load", 256'({nla - a0, 20'd0, dac_a}), 256'({32'd0, 32'hFFF}));

    // R12 trailing bits ignored
    b0 = nlb;
    xfer(272'({16'h52B7, 4'hF}), 20, 1'b0, r);
    chk("R12 dac_b", 256'(dac_b), 256'h2B7);
    chk("R12 single load", 256'(nlb - b0), 1);

    // R1 reset mid-run
    rst_n = 1'b0;
    wait_n(3);
    chk("R1 reset clears", 256'({dac_a, dac_b, conv_mux, conv_gain, conv_bip, miso}), 0);
    rst_n = 1'b1;
    wait_n(4);
    xfer(272'({3'b001, 5'h01, 8'h00}), 16, 1'b0, r);
    chk("R1 ctrl after reset", 256'(r[7:0]), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule